// File: doc/BRIEF.md
# Embedded-Sync Video Frame Capture

This block takes the byte-wide 4:2:2 component video stream that a video decoder produces on its own sample clock. The stream carries its timing as embedded reference codes. The block finds each code, follows the field bit and the vertical-blanking bit, and marks the active-sample window of each line. When a capture request is held high, the block waits for the frame boundary. It then gathers exactly two interlaced fields and stops.

Each chroma byte is joined with the luma byte that follows it into one 16-bit word. Two tag bits travel at the top of each word: one gives the field the data came from, and the other marks a field-boundary word that holds no samples. A storage engine downstream uses that marker to move its write address when it interleaves lines.

The words cross into the system clock domain through a small dual-clock queue. The consumer reads them with an available/read handshake.

Top module: `bt656_capture`

## Requirements
- R1: After reset, `cap_state` is 0 (idle), `word_avail` is low and `overflow` is low.
- R2: While idle, a high `grab_req` moves `cap_state` to 1 (armed, waiting for the frame start) on the next video clock edge.
- R3: A timing code is the byte run FF, 00, 00, then a flag byte whose bit 6 is the field, bit 5 is vertical blanking and bit 4 is 1 for end-of-line and 0 for start-of-line. While armed, the first code whose field bit changes from 1 to 0 starts capture (`cap_state` 2) and queues the boundary word 16'h8000. Codes that do not change the field leave the block armed, and nothing is queued.
- R4: Samples are taken only after a start-of-line code with the blanking bit 0, and only up to the next FF byte. The bytes arrive as chroma, luma, chroma, luma. Each chroma/luma pair becomes one word: bit 15 is 0, bit 14 is the current field, bits 13:7 are chroma[7:1] and bits 6:0 are luma[7:1].
- R5: Lines whose codes carry the blanking bit 1 produce no words, even when they carry samples.
- R6: During capture, a change of the field bit from 0 to 1 queues the boundary word 16'hC000 before any sample of the new field.
- R7: During capture, the next change of the field bit to 0 ends capture (`cap_state` 3) and queues nothing more. The block stays done while `grab_req` is high and returns to idle on the first edge after `grab_req` is low.
- R8: While idle, the incoming stream queues no words, whatever its codes.
- R9: Words leave in the order they were queued. `word_avail` is high while at least one word is queued. A one-cycle `word_rd` while `word_avail` is high removes the word shown on `word_out`.
- R10: A word that arrives while the queue is full is dropped, and the words already queued are kept. `overflow` then goes high and stays high until reset.
- R11: A `word_rd` pulse while `word_avail` is low has no effect on the queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vid_clk | input | 1 | Video sample clock |
| sys_clk | input | 1 | System (consumer) clock |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain through two flops |
| vid_byte | input | 8 | Video stream byte, one per `vid_clk` |
| grab_req | input | 1 | Capture request, already in the video clock domain |
| cap_state | output | 2 | 0 idle, 1 armed, 2 capturing, 3 done (video domain) |
| overflow | output | 1 | Sticky flag, set when a word was dropped (video domain) |
| word_avail | output | 1 | At least one word is queued (system domain) |
| word_rd | input | 1 | One-cycle pop request (system domain) |
| word_out | output | 16 | Head-of-queue word: sync bit 15, field bit 14, chroma 13:7, luma 6:0 |

## Verification
The bench builds the block with `FIFO_AW` set to 3, which gives an eight-word queue. At that size a single captured frame of short lines overfills the queue when the reader is held off. This reaches the drop-on-full path and the sticky flag, and the surviving head words show that the earlier empty pops left the pointers untouched. Lines of one to six random pixels keep whole frames short. These frames still contain blanking lines with payload, stray field-0 codes before the frame start, both field transitions and the closing one, and a return to idle between two captures.

// File: rtl/bt656_cap_pkg.sv
package bt656_cap_pkg;

  localparam int WORD_W    = 16;
  localparam int SAMPLE_W  = 7;
  localparam int SYNC_BIT  = 15;
  localparam int FIELD_BIT = 14;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_ARM  = 2'd1,
    CAP_RUN  = 2'd2,
    CAP_DONE = 2'd3
  } cap_state_e;

endpackage

// File: rtl/bt656_trs_decode.sv
// Finds embedded timing codes and marks the active sample window.
module bt656_trs_decode
  import bt656_cap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          byte_in,
  output logic                trs_vld,
  output logic                trs_field,
  output logic                samp_vld,
  output logic                samp_luma,
  output logic [SAMPLE_W-1:0] samp_hi
);

  logic [7:0] hist1, hist2, hist3;
  logic       active, active_n;
  logic       phase, phase_n;
  logic       is_code;
  logic       is_ff;

  // The current byte is the flag byte when FF 00 00 precede it.
  assign is_code = (hist3 == 8'hFF) && (hist2 == 8'h00) && (hist1 == 8'h00);
  assign is_ff   = (byte_in == 8'hFF);

  always_comb begin
    active_n = active;
    phase_n  = phase;
    if (is_ff) begin
      active_n = 1'b0;
    end else if (is_code && !byte_in[4] && !byte_in[5]) begin
      active_n = 1'b1;
      phase_n  = 1'b0;
    end else if (active) begin
      phase_n  = ~phase;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist1     <= '0;
      hist2     <= '0;
      hist3     <= '0;
      active    <= 1'b0;
      phase     <= 1'b0;
      trs_vld   <= 1'b0;
      trs_field <= 1'b0;
      samp_vld  <= 1'b0;
      samp_luma <= 1'b0;
      samp_hi   <= '0;
    end else begin
      hist1     <= byte_in;
      hist2     <= hist1;
      hist3     <= hist2;
      active    <= active_n;
      phase     <= phase_n;
      trs_vld   <= is_code;
      trs_field <= byte_in[6];
      samp_vld  <= active && !is_ff;
      samp_luma <= phase;
      samp_hi   <= byte_in[7:1];
    end
  end

endmodule

// File: rtl/bt656_cap_seq.sv
// Capture sequencing, sample pairing and word tagging.
module bt656_cap_seq
  import bt656_cap_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                grab_req,
  input  logic                trs_vld,
  input  logic                trs_field,
  input  logic                samp_vld,
  input  logic                samp_luma,
  input  logic [SAMPLE_W-1:0] samp_hi,
  output cap_state_e          state,
  output logic                push,
  output logic [WORD_W-1:0]   wdata
);

  cap_state_e          state_n;
  logic                field_q, field_n;
  logic [SAMPLE_W-1:0] chroma_q, chroma_n;
  logic                push_n;
  logic [WORD_W-1:0]   wdata_n;
  logic                fchg;

  assign fchg = trs_vld && (trs_field != field_q);

  always_comb begin
    state_n  = state;
    push_n   = 1'b0;
    wdata_n  = wdata;
    field_n  = trs_vld ? trs_field : field_q;
    chroma_n = (samp_vld && !samp_luma) ? samp_hi : chroma_q;
    case (state)
      CAP_IDLE: begin
        if (grab_req) state_n = CAP_ARM;
      end
      CAP_ARM: begin
        if (fchg && !trs_field) begin
          state_n = CAP_RUN;
          push_n  = 1'b1;
          wdata_n = WORD_W'(1) << SYNC_BIT;
        end
      end
      CAP_RUN: begin
        if (fchg) begin
          if (trs_field) begin
            push_n  = 1'b1;
            wdata_n = (WORD_W'(1) << SYNC_BIT) | (WORD_W'(1) << FIELD_BIT);
          end else begin
            state_n = CAP_DONE;
          end
        end else if (samp_vld && samp_luma) begin
          push_n  = 1'b1;
          wdata_n = {1'b0, field_q, chroma_q, samp_hi};
        end
      end
      default: begin
        if (!grab_req) state_n = CAP_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= CAP_IDLE;
      field_q  <= 1'b0;
      chroma_q <= '0;
      push     <= 1'b0;
      wdata    <= '0;
    end else begin
      state    <= state_n;
      field_q  <= field_n;
      chroma_q <= chroma_n;
      push     <= push_n;
      wdata    <= wdata_n;
    end
  end

endmodule

// File: rtl/bt656_cdc_fifo.sv
// Dual-clock queue with Gray pointers, drop-on-full and show-ahead read.
module bt656_cdc_fifo #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  output logic          overflow,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          pop,
  output logic          avail,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [DW-1:0] mem [DEPTH];

  logic [PW-1:0] wbin, wbin_n, wgray, rg_s1, rg_s2;
  logic [PW-1:0] rbin, rbin_n, rgray, wg_s1, wg_s2;
  logic          full, empty, wr_en, rd_en;

  // Write side
  assign full   = (wgray == {~rg_s2[AW:AW-1], rg_s2[AW-2:0]});
  assign wr_en  = push && !full;
  assign wbin_n = wbin + PW'(wr_en);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin     <= '0;
      wgray    <= '0;
      rg_s1    <= '0;
      rg_s2    <= '0;
      overflow <= 1'b0;
    end else begin
      wbin     <= wbin_n;
      wgray    <= wbin_n ^ (wbin_n >> 1);
      rg_s1    <= rgray;
      rg_s2    <= rg_s1;
      overflow <= overflow | (push && full);
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_en) mem[wbin[AW-1:0]] <= wdata;
  end

  // Read side
  assign empty  = (rgray == wg_s2);
  assign rd_en  = pop && !empty;
  assign rbin_n = rbin + PW'(rd_en);
  assign avail  = !empty;
  assign rdata  = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wg_s1 <= '0;
      wg_s2 <= '0;
    end else begin
      rbin  <= rbin_n;
      rgray <= rbin_n ^ (rbin_n >> 1);
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
    end
  end

endmodule

// File: rtl/bt656_capture.sv
module bt656_capture
  import bt656_cap_pkg::*;
#(
  parameter int FIFO_AW = 10
) (
  input  logic              vid_clk,
  input  logic              sys_clk,
  input  logic              rst_n,
  input  logic [7:0]        vid_byte,
  input  logic              grab_req,
  output logic [1:0]        cap_state,
  output logic              overflow,
  output logic              word_avail,
  input  logic              word_rd,
  output logic [WORD_W-1:0] word_out
);

  logic [1:0]          vid_rst_q, sys_rst_q;
  logic                vid_rst_n_s, sys_rst_n_s;
  logic                trs_vld, trs_field, samp_vld, samp_luma;
  logic [SAMPLE_W-1:0] samp_hi;
  cap_state_e          seq_state;
  logic                seq_push;
  logic [WORD_W-1:0]   seq_wdata;

  always_ff @(posedge vid_clk or negedge rst_n) begin
    if (!rst_n) vid_rst_q <= 2'b00;
    else        vid_rst_q <= {vid_rst_q[0], 1'b1};
  end

  always_ff @(posedge sys_clk or negedge rst_n) begin
    if (!rst_n) sys_rst_q <= 2'b00;
    else        sys_rst_q <= {sys_rst_q[0], 1'b1};
  end

  assign vid_rst_n_s = vid_rst_q[1];
  assign sys_rst_n_s = sys_rst_q[1];

  bt656_trs_decode u_dec (
    .clk       (vid_clk),
    .rst_n     (vid_rst_n_s),
    .byte_in   (vid_byte),
    .trs_vld   (trs_vld),
    .trs_field (trs_field),
    .samp_vld  (samp_vld),
    .samp_luma (samp_luma),
    .samp_hi   (samp_hi)
  );

  bt656_cap_seq u_seq (
    .clk       (vid_clk),
    .rst_n     (vid_rst_n_s),
    .grab_req  (grab_req),
    .trs_vld   (trs_vld),
    .trs_field (trs_field),
    .samp_vld  (samp_vld),
    .samp_luma (samp_luma),
    .samp_hi   (samp_hi),
    .state     (seq_state),
    .push      (seq_push),
    .wdata     (seq_wdata)
  );

  bt656_cdc_fifo #(
    .AW (FIFO_AW),
    .DW (WORD_W)
  ) u_fifo (
    .wclk     (vid_clk),
    .wrst_n   (vid_rst_n_s),
    .push     (seq_push),
    .wdata    (seq_wdata),
    .overflow (overflow),
    .rclk     (sys_clk),
    .rrst_n   (sys_rst_n_s),
    .pop      (word_rd),
    .avail    (word_avail),
    .rdata    (word_out)
  );

  assign cap_state = seq_state;

endmodule

// File: rtl/bt656_capture_chk.sv
module bt656_capture_chk (
  input logic       vid_clk,
  input logic       vid_rst_n_s,
  input logic       grab_req,
  input logic [1:0] cap_state,
  input logic       overflow,
  input logic       push
);

  a_r2_grab_arms: assert property (@(posedge vid_clk) disable iff (!vid_rst_n_s)
    (cap_state == 2'd0 && grab_req) |=> (cap_state == 2'd1));

  a_r7_done_holds: assert property (@(posedge vid_clk) disable iff (!vid_rst_n_s)
    (cap_state == 2'd3 && grab_req) |=> (cap_state == 2'd3));

  a_r7_done_release: assert property (@(posedge vid_clk) disable iff (!vid_rst_n_s)
    (cap_state == 2'd3 && !grab_req) |=> (cap_state == 2'd0));

  // R8 and R3: words enter the queue only while capturing
  a_r8_push_only_capturing: assert property (@(posedge vid_clk) disable iff (!vid_rst_n_s)
    push |-> (cap_state == 2'd2));

  a_r10_overflow_sticky: assert property (@(posedge vid_clk) disable iff (!vid_rst_n_s)
    overflow |=> overflow);

endmodule

bind bt656_capture bt656_capture_chk u_chk (
  .vid_clk     (vid_clk),
  .vid_rst_n_s (vid_rst_n_s),
  .grab_req    (grab_req),
  .cap_state   (cap_state),
  .overflow    (overflow),
  .push        (seq_push)
);

// File: tb/tb_bt656_capture.sv
`timescale 1ns/100ps
module tb_bt656_capture;

  localparam int FAW   = 3;
  localparam int DEPTH = 1 << FAW;

  logic        vid_clk = 1'b0;
  logic        sys_clk = 1'b0;
  logic        rst_n;
  logic [7:0]  vid_byte;
  logic        grab_req;
  logic [1:0]  cap_state;
  logic        overflow;
  logic        word_avail;
  logic        word_rd;
  logic [15:0] word_out;

  always #2    sys_clk = ~sys_clk;
  always #18.5 vid_clk = ~vid_clk;

  bt656_capture #(.FIFO_AW(FAW)) dut (
    .vid_clk    (vid_clk),
    .sys_clk    (sys_clk),
    .rst_n      (rst_n),
    .vid_byte   (vid_byte),
    .grab_req   (grab_req),
    .cap_state  (cap_state),
    .overflow   (overflow),
    .word_avail (word_avail),
    .word_rd    (word_rd),
    .word_out   (word_out)
  );

  int          checks = 0;
  int          fails  = 0;
  logic [15:0] exp_q[$];
  bit          rd_en = 1'b0;
  int          pokes_req = 0;
  int          pokes_done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string word_tag(input logic [15:0] w);
    if (w[15] && !w[14]) return "R3 field-0 boundary word";
    if (w[15])           return "R6 field-1 boundary word";
    return "R4 sample word (R9 order)";
  endfunction

  function automatic logic [7:0] flag_byte(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [7:0] rnd_sample();
    return 8'(1 + ($urandom % 254));
  endfunction

  // Reader: one pop every other system cycle, plus requested empty pops
  always @(negedge sys_clk) begin
    if (word_rd) begin
      word_rd = 1'b0;
    end else if (pokes_done < pokes_req) begin
      word_rd = 1'b1;
      pokes_done++;
    end else if (rd_en && word_avail) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 word after capture end", 32'(word_out), 32'h0);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(word_out == e, word_tag(e), 32'(word_out), 32'(e));
      end
      word_rd = 1'b1;
    end
  end

  task automatic put_byte(input logic [7:0] b);
    @(negedge vid_clk);
    vid_byte = b;
  endtask

  task automatic put_code(input logic f, input logic v, input logic h);
    put_byte(8'hFF);
    put_byte(8'h00);
    put_byte(8'h00);
    put_byte(flag_byte(f, v, h));
  endtask

  // One line: end code, blanking, start code, 2*npix payload bytes
  task automatic send_line(input logic f, input logic v, input int npix, input bit rec);
    put_code(f, v, 1'b1);
    for (int i = 0; i < 2; i++) begin
      put_byte(8'h80);
      put_byte(8'h10);
    end
    put_code(f, v, 1'b0);
    for (int k = 0; k < npix; k++) begin
      logic [7:0] c, l;
      c = rnd_sample();
      l = rnd_sample();
      put_byte(c);
      put_byte(l);
      if (rec && !v) exp_q.push_back({1'b0, f, c[7:1], l[7:1]});
    end
  endtask

  task automatic capture_frame(input int minpix);
    send_line(1'b1, 1'b1, 3, 1'b0);
    send_line(1'b1, 1'b0, 3, 1'b0);
    exp_q.push_back(16'h8000);
    send_line(1'b0, 1'b1, 3, 1'b0);               // R5: blanking line with payload
    for (int i = 0; i < 3; i++) send_line(1'b0, 1'b0, minpix + int'($urandom % 4), 1'b1);
    exp_q.push_back(16'hC000);
    send_line(1'b1, 1'b1, 3, 1'b0);
    for (int i = 0; i < 3; i++) send_line(1'b1, 1'b0, minpix + int'($urandom % 4), 1'b1);
    send_line(1'b0, 1'b0, 4, 1'b0);               // R7: closing field change
  endtask

  task automatic sys_wait(input int n);
    repeat (n) @(negedge sys_clk);
  endtask

  initial begin
    repeat (100000) @(posedge sys_clk);
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n    = 1'b0;
    grab_req = 1'b0;
    vid_byte = 8'h80;
    word_rd  = 1'b0;
    repeat (10) @(negedge vid_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge vid_clk);
    sys_wait(1);
    chk(cap_state == 2'd0, "R1 state after reset", 32'(cap_state), 32'd0);
    chk(word_avail == 1'b0, "R1 avail after reset", 32'(word_avail), 32'd0);
    chk(overflow == 1'b0, "R1 overflow after reset", 32'(overflow), 32'd0);
    rd_en = 1'b1;

    // R8: stream with field changes while idle
    send_line(1'b1, 1'b0, 3, 1'b0);
    send_line(1'b0, 1'b0, 3, 1'b0);
    sys_wait(20);
    chk(cap_state == 2'd0, "R8 idle kept", 32'(cap_state), 32'd0);
    chk(word_avail == 1'b0, "R8 no words while idle", 32'(word_avail), 32'd0);

    // R2: arm
    @(negedge vid_clk);
    grab_req = 1'b1;
    repeat (2) @(negedge vid_clk);
    chk(cap_state == 2'd1, "R2 armed", 32'(cap_state), 32'd1);

    // R3: codes without a 1->0 field change keep it armed
    send_line(1'b0, 1'b0, 3, 1'b0);
    sys_wait(20);
    chk(cap_state == 2'd1, "R3 still armed", 32'(cap_state), 32'd1);
    chk(word_avail == 1'b0, "R3 nothing queued while armed", 32'(word_avail), 32'd0);

    capture_frame(1);
    sys_wait(60);
    chk(exp_q.size() == 0, "R9 all words delivered", 32'(exp_q.size()), 32'd0);
    chk(word_avail == 1'b0, "R9 avail low when drained", 32'(word_avail), 32'd0);
    chk(cap_state == 2'd3, "R7 done", 32'(cap_state), 32'd3);
    chk(overflow == 1'b0, "R10 no overflow with steady reader", 32'(overflow), 32'd0);

    send_line(1'b1, 1'b0, 4, 1'b0);
    send_line(1'b0, 1'b0, 4, 1'b0);
    sys_wait(20);
    chk(cap_state == 2'd3, "R7 done held while requested", 32'(cap_state), 32'd3);
    chk(word_avail == 1'b0, "R7 no words after end", 32'(word_avail), 32'd0);

    @(negedge vid_clk);
    grab_req = 1'b0;
    repeat (2) @(negedge vid_clk);
    chk(cap_state == 2'd0, "R7 back to idle", 32'(cap_state), 32'd0);

    // Second capture with the reader held off
    rd_en = 1'b0;
    pokes_req += 3;
    sys_wait(20);
    chk(word_avail == 1'b0, "R11 empty pops leave queue empty", 32'(word_avail), 32'd0);
    @(negedge vid_clk);
    grab_req = 1'b1;
    capture_frame(3);
    sys_wait(60);
    chk(cap_state == 2'd3, "R7 done second frame", 32'(cap_state), 32'd3);
    chk(overflow == 1'b1, "R10 overflow set", 32'(overflow), 32'd1);
    chk(word_avail == 1'b1, "R10 kept words available", 32'(word_avail), 32'd1);
    while (exp_q.size() > DEPTH) void'(exp_q.pop_back());
    rd_en = 1'b1;
    sys_wait(80);
    chk(exp_q.size() == 0, "R10 oldest words kept", 32'(exp_q.size()), 32'd0);
    chk(word_avail == 1'b0, "R10 later words dropped", 32'(word_avail), 32'd0);
    chk(overflow == 1'b1, "R10 overflow sticky", 32'(overflow), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule